// File: doc/BRIEF.md
# PCI I/O Window Address Translator

This block sits between a 32-bit CPU request port and the downstream PCI side of a host bridge. Every CPU access is classified against three targets: an 8 MB I/O window at 0x8000_0000, a single interrupt-acknowledge byte at 0xBFFF_FFF0, and a PCI memory window of 0x3F00_0000 bytes starting at 0xC000_0000. I/O accesses are turned into 16-bit PCI port numbers. PCI memory accesses are turned into offsets into the memory window. The result goes out as a registered strobe exactly one cycle after the request.

A level input, `map_sparse`, picks how the I/O window folds into the port space. The input is sampled on every access, so software may change it between any two accesses. With the input low, the window behaves as a flat 64 KB port map that repeats across the window. With the input high, the window is sparse: each 4 KB page of CPU space reaches only 32 consecutive ports, and the page number supplies the upper port bits.

Accesses of 1, 2 or 4 bytes are passed on at any alignment, with little-endian byte lanes over a two-word lane field. Any other access is rejected with a one-cycle decode-error strobe and issues nothing downstream: a bad size, an address outside every window, or a wider-than-byte access to the acknowledge location.

Top module: `pio_window_xlat`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `io_req`, `mem_req`, `iack_stb` and `err_stb` are all low.
- R2: A CPU request whose address lies in 0x8000_0000..0x807F_FFFF and whose size is 1, 2 or 4 raises `io_req` for one cycle, on the clock edge after the request. `dn_we` on that cycle equals the request's `cpu_we`.
- R3: With `map_sparse` low, the I/O port on `dn_addr[15:0]` equals CPU address bits [15:0]. `dn_addr[31:16]` is zero.
- R4: With `map_sparse` high, the I/O port is formed as {addr[22:12], addr[4:0]}. CPU address bits [11:5] are dropped.
- R5: The mapping follows the `map_sparse` level of each individual access. Two back-to-back accesses to the same address under different levels get different ports.
- R6: `cpu_size` is a byte count. `dn_be` is ((1<<size)-1) shifted left by addr[1:0] within 8 bits. `dn_wdata` is the low `size` bytes of `cpu_wdata` shifted left by 8*addr[1:0] within 64 bits, so byte k lands in lane addr[1:0]+k (little-endian). Unaligned accesses are accepted.
- R7: A 1-byte read at 0xBFFF_FFF0 raises `iack_stb` on the next cycle, with `iack_data` equal to `iack_vector` as sampled with the request.
- R8: A 1-byte write at 0xBFFF_FFF0 is ignored: no strobe of any kind follows.
- R9: An access to 0xBFFF_FFF0 of any size other than 1 raises `err_stb`.
- R10: A request in 0xC000_0000..0xFEFF_FFFF with a legal size raises `mem_req` on the next cycle, with `dn_addr` = address − 0xC000_0000.
- R11: A size other than 1, 2 or 4 raises `err_stb` on the next cycle and neither `io_req` nor `mem_req`.
- R12: An address outside all three targets (for example below 0x8000_0000, 0x8080_0000, or 0xFF00_0000 and above) raises `err_stb` on the next cycle.
- R13: In any cycle at most one of `io_req`, `mem_req`, `iack_stb`, `err_stb` is high, and none is high in the cycle after a cycle without `cpu_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access present this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 3 | Access size in bytes |
| cpu_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| map_sparse | input | 1 | I/O map select: 0 flat, 1 sparse |
| iack_vector | input | 8 | Vector offered by the interrupt controller |
| io_req | output | 1 | Downstream I/O cycle strobe |
| mem_req | output | 1 | Downstream memory cycle strobe |
| iack_stb | output | 1 | Interrupt-acknowledge read completed |
| err_stb | output | 1 | Decode error on the last request |
| dn_we | output | 1 | Write flag of the downstream cycle |
| dn_addr | output | 32 | Port number or memory-window offset |
| dn_be | output | 8 | Byte enables across two words |
| dn_wdata | output | 64 | Write data placed on its byte lanes |
| iack_data | output | 8 | Captured acknowledge vector |

## Verification
The assertions take the request inputs, `map_sparse` and `iack_vector` as stable, known values around each rising edge. They compare the registered outputs against the values these inputs had one edge earlier. The bench therefore changes every input only on the falling edge and holds each request for exactly one cycle, so each output cycle belongs to one request. Both levels of the mode input are applied, including a switch between consecutive accesses to the same address, so that the per-access sampling is exercised rather than assumed.

// File: rtl/pio_xlat_pkg.sv
package pio_xlat_pkg;
    localparam int AW      = 32;
    localparam int LANES   = 4;
    localparam int DW      = 8 * LANES;
    localparam int BEW     = 2 * LANES;
    localparam int WW      = 2 * DW;
    localparam int SIZE_W  = 3;
    localparam int VEC_W   = 8;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_IO,
        RG_IACK,
        RG_MEM
    } region_e;

    typedef struct packed {
        logic             io_req;
        logic             mem_req;
        logic             iack_stb;
        logic             err_stb;
        logic             we;
        logic [AW-1:0]    addr;
        logic [BEW-1:0]   be;
        logic [WW-1:0]    wdata;
        logic [VEC_W-1:0] iack_data;
    } dn_t;
endpackage

// File: rtl/pio_region_dec.sv
module pio_region_dec
    import pio_xlat_pkg::*;
#(
    parameter logic [AW-1:0] IO_BASE      = 32'h8000_0000,
    parameter int            IO_SPAN_LOG2 = 23,
    parameter logic [AW-1:0] IACK_ADDR    = 32'hBFFF_FFF0,
    parameter logic [AW-1:0] MEM_BASE     = 32'hC000_0000,
    parameter logic [AW-1:0] MEM_SPAN     = 32'h3F00_0000
) (
    input  logic [AW-1:0]           addr,
    output region_e                 region,
    output logic [IO_SPAN_LOG2-1:0] io_off,
    output logic [AW-1:0]           mem_off
);
    logic io_hit;
    logic mem_hit;
    logic iack_hit;

    // The I/O window is naturally aligned, so a compare of the upper bits decides it.
    assign io_hit   = (addr[AW-1:IO_SPAN_LOG2] == IO_BASE[AW-1:IO_SPAN_LOG2]);
    assign mem_off  = addr - MEM_BASE;
    assign mem_hit  = (addr >= MEM_BASE) && (mem_off < MEM_SPAN);
    assign iack_hit = (addr == IACK_ADDR);
    assign io_off   = addr[IO_SPAN_LOG2-1:0];

    always_comb begin
        if (iack_hit)     region = RG_IACK;
        else if (io_hit)  region = RG_IO;
        else if (mem_hit) region = RG_MEM;
        else              region = RG_NONE;
    end
endmodule

// File: rtl/pio_port_fold.sv
module pio_port_fold #(
    parameter int IO_SPAN_LOG2 = 23,
    parameter int PORT_W       = 16,
    parameter int PAGE_LOG2    = 12,
    parameter int KEEP_LO      = 5
) (
    input  logic [IO_SPAN_LOG2-1:0] io_off,
    input  logic                    sparse,
    output logic [PORT_W-1:0]       port
);
    localparam int SPARSE_W = IO_SPAN_LOG2 - PAGE_LOG2 + KEEP_LO;

    logic [PORT_W-1:0] flat_port;
    logic [PORT_W-1:0] sparse_port;

    assign flat_port = io_off[PORT_W-1:0];

    generate
        if (SPARSE_W >= PORT_W) begin : g_sp_trunc
            logic [SPARSE_W-1:0] sp_full;
            assign sp_full     = {io_off[IO_SPAN_LOG2-1:PAGE_LOG2], io_off[KEEP_LO-1:0]};
            assign sparse_port = sp_full[PORT_W-1:0];
        end else begin : g_sp_ext
            assign sparse_port = PORT_W'({io_off[IO_SPAN_LOG2-1:PAGE_LOG2], io_off[KEEP_LO-1:0]});
        end
    endgenerate

    assign port = sparse ? sparse_port : flat_port;
endmodule

// File: rtl/pio_lane_map.sv
module pio_lane_map
    import pio_xlat_pkg::*;
(
    input  logic [1:0]        lane,
    input  logic [SIZE_W-1:0] size,
    input  logic [DW-1:0]     wdata,
    output logic [BEW-1:0]    be,
    output logic [WW-1:0]     wdata_out
);
    logic [LANES-1:0] mask;
    logic [DW-1:0]    kept;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign mask[k]        = (SIZE_W'(k) < size);
            assign kept[8*k +: 8] = mask[k] ? wdata[8*k +: 8] : 8'h00;
        end
    endgenerate

    assign be        = BEW'(mask) << lane;
    assign wdata_out = WW'(kept) << {lane, 3'b000};
endmodule

// File: rtl/pio_window_xlat.sv
module pio_window_xlat
    import pio_xlat_pkg::*;
#(
    parameter logic [AW-1:0] IO_BASE      = 32'h8000_0000,
    parameter int            IO_SPAN_LOG2 = 23,
    parameter int            PORT_W       = 16,
    parameter logic [AW-1:0] IACK_ADDR    = 32'hBFFF_FFF0,
    parameter logic [AW-1:0] MEM_BASE     = 32'hC000_0000,
    parameter logic [AW-1:0] MEM_SPAN     = 32'h3F00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [2:0]        cpu_size,
    input  logic [31:0]       cpu_wdata,
    input  logic              map_sparse,
    input  logic [7:0]        iack_vector,
    output logic              io_req,
    output logic              mem_req,
    output logic              iack_stb,
    output logic              err_stb,
    output logic              dn_we,
    output logic [31:0]       dn_addr,
    output logic [7:0]        dn_be,
    output logic [63:0]       dn_wdata,
    output logic [7:0]        iack_data
);
    region_e                 region;
    logic [IO_SPAN_LOG2-1:0] io_off;
    logic [AW-1:0]           mem_off;
    logic [PORT_W-1:0]       port;
    logic [BEW-1:0]          lane_be;
    logic [WW-1:0]           lane_wdata;
    logic                    size_ok;
    dn_t                     out_d;
    dn_t                     out_q;

    pio_region_dec #(
        .IO_BASE      (IO_BASE),
        .IO_SPAN_LOG2 (IO_SPAN_LOG2),
        .IACK_ADDR    (IACK_ADDR),
        .MEM_BASE     (MEM_BASE),
        .MEM_SPAN     (MEM_SPAN)
    ) u_dec (
        .addr    (cpu_addr),
        .region  (region),
        .io_off  (io_off),
        .mem_off (mem_off)
    );

    pio_port_fold #(
        .IO_SPAN_LOG2 (IO_SPAN_LOG2),
        .PORT_W       (PORT_W)
    ) u_fold (
        .io_off (io_off),
        .sparse (map_sparse),
        .port   (port)
    );

    pio_lane_map u_lanes (
        .lane      (cpu_addr[1:0]),
        .size      (cpu_size),
        .wdata     (cpu_wdata),
        .be        (lane_be),
        .wdata_out (lane_wdata)
    );

    assign size_ok = (cpu_size == 3'd1) || (cpu_size == 3'd2) || (cpu_size == 3'd4);

    always_comb begin
        out_d = '0;
        if (cpu_req) begin
            if (!size_ok) begin
                out_d.err_stb = 1'b1;
            end else begin
                unique case (region)
                    RG_IO: begin
                        out_d.io_req = 1'b1;
                        out_d.we     = cpu_we;
                        out_d.addr   = AW'(port);
                        out_d.be     = lane_be;
                        out_d.wdata  = lane_wdata;
                    end
                    RG_MEM: begin
                        out_d.mem_req = 1'b1;
                        out_d.we      = cpu_we;
                        out_d.addr    = mem_off;
                        out_d.be      = lane_be;
                        out_d.wdata   = lane_wdata;
                    end
                    RG_IACK: begin
                        if (cpu_size != 3'd1) begin
                            out_d.err_stb = 1'b1;
                        end else if (!cpu_we) begin
                            out_d.iack_stb  = 1'b1;
                            out_d.iack_data = iack_vector;
                        end
                    end
                    default: begin
                        out_d.err_stb = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign io_req    = out_q.io_req;
    assign mem_req   = out_q.mem_req;
    assign iack_stb  = out_q.iack_stb;
    assign err_stb   = out_q.err_stb;
    assign dn_we     = out_q.we;
    assign dn_addr   = out_q.addr;
    assign dn_be     = out_q.be;
    assign dn_wdata  = out_q.wdata;
    assign iack_data = out_q.iack_data;
endmodule

// File: rtl/pio_xlat_chk.sv
module pio_xlat_chk #(
    parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [31:0] cpu_addr,
    input logic [2:0]  cpu_size,
    input logic        map_sparse,
    input logic [7:0]  iack_vector,
    input logic        io_req,
    input logic        mem_req,
    input logic        iack_stb,
    input logic        err_stb,
    input logic [31:0] dn_addr,
    input logic [7:0]  iack_data
);
    logic any_stb;
    logic size_legal;
    assign any_stb    = io_req | mem_req | iack_stb | err_stb;
    assign size_legal = (cpu_size == 3'd1) || (cpu_size == 3'd2) || (cpu_size == 3'd4);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_req, mem_req, iack_stb, err_stb})); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> !any_stb); // R13

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !size_legal) |=> (err_stb && !io_req && !mem_req)); // R11

    AST_IACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        iack_stb |-> (iack_data == $past(iack_vector))); // R7

    AST_IACK_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_addr == IACK_ADDR && cpu_size == 3'd1) |=> !any_stb); // R8

    AST_FLAT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !$past(map_sparse)) |-> (dn_addr[15:0] == $past(cpu_addr[15:0]))); // R3

    AST_SPARSE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && $past(map_sparse)) |->
            (dn_addr[15:0] == {$past(cpu_addr[22:12]), $past(cpu_addr[4:0])})); // R4
endmodule

bind pio_window_xlat pio_xlat_chk #(.IACK_ADDR(IACK_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_size    (cpu_size),
    .map_sparse  (map_sparse),
    .iack_vector (iack_vector),
    .io_req      (io_req),
    .mem_req     (mem_req),
    .iack_stb    (iack_stb),
    .err_stb     (err_stb),
    .dn_addr     (dn_addr),
    .iack_data   (iack_data)
);

// File: tb/tb_pio_window_xlat.sv
`timescale 1ns/1ps
module tb_pio_window_xlat;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req;
    logic        cpu_we;
    logic [31:0] cpu_addr;
    logic [2:0]  cpu_size;
    logic [31:0] cpu_wdata;
    logic        map_sparse;
    logic [7:0]  iack_vector;
    logic        io_req, mem_req, iack_stb, err_stb, dn_we;
    logic [31:0] dn_addr;
    logic [7:0]  dn_be;
    logic [63:0] dn_wdata;
    logic [7:0]  iack_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pio_window_xlat dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .map_sparse(map_sparse), .iack_vector(iack_vector),
        .io_req(io_req), .mem_req(mem_req), .iack_stb(iack_stb), .err_stb(err_stb),
        .dn_we(dn_we), .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .iack_data(iack_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe vector {io, mem, iack, err}
    task automatic check_stb(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {io_req, mem_req, iack_stb, err_stb};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    function automatic logic [7:0] exp_be(input logic [31:0] a, input logic [2:0] s);
        logic [7:0] m;
        m = 8'((9'd1 << s) - 9'd1);
        return m << a[1:0];
    endfunction

    function automatic logic [63:0] exp_wd(input logic [31:0] a, input logic [2:0] s, input logic [31:0] d);
        logic [63:0] m;
        m = (64'd1 << (8 * s)) - 64'd1;
        return (64'(d) & m) << (8 * a[1:0]);
    endfunction

    // Present one request for one cycle; outputs are valid at the following falling edge.
    task automatic access(input bit we, input logic [31:0] a, input logic [2:0] s,
                          input logic [31:0] d, input bit sp, input logic [7:0] vec);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = s;
        cpu_wdata = d; map_sparse = sp; iack_vector = vec;
        @(negedge clk);
        cpu_req = 1'b0; iack_vector = 8'h00;
    endtask

    task automatic t_reset;
        check_stb(4'b0000, "R1 strobes in reset");
        @(negedge clk); rst_n = 1'b1;
        check_stb(4'b0000, "R1 strobes after reset");
    endtask

    task automatic t_io_flat;
        access(1'b1, 32'h8012_3456, 3'd2, 32'h0000_BEEF, 1'b0, 8'h00);
        check_stb(4'b1000, "R2 io strobe");
        check(dn_we == 1'b1, "R2 write flag", 64'(dn_we), 64'd1);
        check(dn_addr == 32'h0000_3456, "R3 flat port", 64'(dn_addr), 64'h3456);
        check(dn_be == exp_be(32'h8012_3456, 3'd2), "R6 be", 64'(dn_be), 64'(exp_be(32'h8012_3456, 3'd2)));
        check(dn_wdata == exp_wd(32'h8012_3456, 3'd2, 32'h0000_BEEF), "R6 wdata", dn_wdata,
              exp_wd(32'h8012_3456, 3'd2, 32'h0000_BEEF));
        @(negedge clk);
        check_stb(4'b0000, "R13 idle after request");
    endtask

    task automatic t_io_sparse;
        logic [31:0] a;
        logic [15:0] p;
        a = 32'h8054_3A1D;
        p = {a[22:12], a[4:0]};
        access(1'b0, a, 3'd1, 32'h0, 1'b1, 8'h00);
        check_stb(4'b1000, "R2 io strobe sparse");
        check(dn_we == 1'b0, "R2 read flag", 64'(dn_we), 64'd0);
        check(dn_addr == 32'(p), "R4 sparse port", 64'(dn_addr), 64'(p));
        check(dn_be == 8'h02, "R6 byte lane 1", 64'(dn_be), 64'h02);
    endtask

    task automatic t_mode_switch;
        logic [31:0] a;
        a = 32'h8001_2345;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_size = 3'd1; map_sparse = 1'b0;
        @(negedge clk);
        check(dn_addr == 32'h0000_2345, "R5 first access flat", 64'(dn_addr), 64'h2345);
        map_sparse = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        check(dn_addr == 32'(16'({a[22:12], a[4:0]})), "R5 second access sparse",
              64'(dn_addr), 64'({a[22:12], a[4:0]}));
        check_stb(4'b1000, "R5 io strobe");
    endtask

    task automatic t_unaligned;
        logic [31:0] a;
        a = 32'h8000_0103;
        access(1'b1, a, 3'd4, 32'h1122_3344, 1'b0, 8'h00);
        check_stb(4'b1000, "R6 unaligned accepted");
        check(dn_be == 8'h78, "R6 unaligned be", 64'(dn_be), 64'h78);
        check(dn_wdata == 64'h0011_2233_4400_0000, "R6 unaligned wdata", dn_wdata, 64'h0011_2233_4400_0000);
    endtask

    task automatic t_iack;
        access(1'b0, 32'hBFFF_FFF0, 3'd1, 32'h0, 1'b0, 8'h5A);
        check_stb(4'b0010, "R7 iack strobe");
        check(iack_data == 8'h5A, "R7 iack vector", 64'(iack_data), 64'h5A);
        access(1'b1, 32'hBFFF_FFF0, 3'd1, 32'hFF, 1'b0, 8'h33);
        check_stb(4'b0000, "R8 iack write ignored");
        access(1'b0, 32'hBFFF_FFF0, 3'd2, 32'h0, 1'b0, 8'h33);
        check_stb(4'b0001, "R9 iack wide access");
    endtask

    task automatic t_mem;
        access(1'b1, 32'hC123_4568, 3'd4, 32'hCAFE_F00D, 1'b0, 8'h00);
        check_stb(4'b0100, "R10 mem strobe");
        check(dn_addr == 32'h0123_4568, "R10 mem offset", 64'(dn_addr), 64'h0123_4568);
        check(dn_be == 8'h0F, "R6 mem be", 64'(dn_be), 64'h0F);
        access(1'b0, 32'hFEFF_FFFF, 3'd1, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0100, "R10 mem top byte");
        check(dn_addr == 32'h3EFF_FFFF, "R10 mem top offset", 64'(dn_addr), 64'h3EFF_FFFF);
    endtask

    task automatic t_bad_size;
        access(1'b1, 32'h8000_0010, 3'd3, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0001, "R11 size 3");
        access(1'b0, 32'hC000_0000, 3'd0, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0001, "R11 size 0");
    endtask

    task automatic t_unmapped;
        access(1'b0, 32'h807F_FFFF, 3'd1, 32'h0, 1'b0, 8'h00);
        check_stb(4'b1000, "R2 last io byte");
        access(1'b0, 32'h8080_0000, 3'd1, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0001, "R12 above io window");
        access(1'b0, 32'h0000_1000, 3'd4, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0001, "R12 low memory");
        access(1'b0, 32'hFF00_0000, 3'd1, 32'h0, 1'b0, 8'h00);
        check_stb(4'b0001, "R12 above mem window");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_size = '0;
        cpu_wdata = '0; map_sparse = 1'b0; iack_vector = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_io_flat();
        t_io_sparse();
        t_mode_switch();
        t_unaligned();
        t_iack();
        t_mem();
        t_bad_size();
        t_unmapped();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule